// File: doc/BRIEF.md
# Dual-Direction Latched Bus Transceiver

This block joins an A port and a B port with a 16-bit data path that can carry data in either direction. The path is split into two 8-bit groups. Each group has two storage banks, one for each direction. Each bank has its own three active-low controls: a chip enable, a latch enable and an output enable. A bank that is enabled and whose latch enable is low copies its source port on every system clock edge, so it acts as a transparent latch in clocked form. When its latch enable is high, the bank keeps the word it last captured.

No tri-state pins are used. Each group drives each port through a data bus and a drive-enable bit. A bus whose drive enable is off reads as zero. A per-group contention flag goes high whenever a group drives both ports in the same cycle.

The data moves by plain level controls and has no handshake, so no port ever applies back-pressure. A downstream consumer takes a group's bus as valid whenever that group's drive enable is high.

Top module: `dual_latch_xcvr`

## Requirements
- R1: Each 8-bit group g (bits 8g+7..8g) responds only to its own control bits (index g of each control vector). Controls of one group never change the other group's stored data or drive state.
- R2: A→B load: at a clock edge where `ab_ce_n[g]` and `ab_le_n[g]` are both sampled low and reset is low, the group's A→B bank captures `a_in` bits of group g. The new value is visible from that edge.
- R3: A→B hold: at an edge where `ab_le_n[g]` is high, the A→B bank keeps its value and ignores `a_in`.
- R4: While `ab_ce_n[g]` is high, the A→B bank neither loads nor drives, whatever `ab_le_n[g]` and `ab_oe_n[g]` are.
- R5: `b_drv[g]` is 1 exactly when reset is low and `ab_ce_n[g]` and `ab_oe_n[g]` are both low. While it is 1, the group's slice of `b_out` equals the A→B bank contents.
- R6: `ab_oe_n` (and `ba_oe_n`) has no effect on bank contents. A bank loads while its outputs are disabled.
- R7: The B→A direction mirrors R2 to R6, using `ba_ce_n`, `ba_le_n`, `ba_oe_n`, source `b_in`, outputs `a_out` and `a_drv`.
- R8: When a group's drive enable on a port is 0, that group's slice of the port's data bus is all zeros.
- R9: `clash[g]` is 1 exactly when `a_drv[g]` and `b_drv[g]` are both 1.
- R10: Synchronous reset (`rst` high at an edge) clears all four banks to zero. While `rst` is high, every drive enable is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous reset, active high |
| a_in | input | 16 | A port data sampled by the A→B banks |
| b_in | input | 16 | B port data sampled by the B→A banks |
| ab_ce_n | input | 2 | A→B chip enable per group, active low |
| ab_le_n | input | 2 | A→B latch enable per group, active low |
| ab_oe_n | input | 2 | A→B output enable per group, active low |
| ba_ce_n | input | 2 | B→A chip enable per group, active low |
| ba_le_n | input | 2 | B→A latch enable per group, active low |
| ba_oe_n | input | 2 | B→A output enable per group, active low |
| b_out | output | 16 | Data driven toward the B port |
| b_drv | output | 2 | Per-group drive enable for `b_out` |
| a_out | output | 16 | Data driven toward the A port |
| a_drv | output | 2 | Per-group drive enable for `a_out` |
| clash | output | 2 | Per-group flag: both directions are driving |

## Verification
A bank that loads when it should hold, or holds when it should load, is hidden while its output is disabled. It shows on the data bus in the first cycle its output enable is low. For this reason the bench loads banks with outputs off and reads them back later.

A drive-enable decode error shows in the same cycle as the control change, either as a wrong drive bit or as a nonzero undriven slice. A group-index error shows as one group's data or flag moving when only the other group's controls changed.

// File: rtl/xcvr_pkg.sv
package xcvr_pkg;
  typedef struct packed {
    logic ce_n;
    logic le_n;
    logic oe_n;
  } dir_ctl_t;
endpackage

// File: rtl/xcvr_latch_bank.sv
module xcvr_latch_bank #(
  parameter int W = 8
) (
  input  logic               clk,
  input  logic               rst,
  input  xcvr_pkg::dir_ctl_t ctl,
  input  logic [W-1:0]       din,
  output logic [W-1:0]       dout,
  output logic               drv
);
  logic [W-1:0] store_q;
  logic         load;

  assign load = !ctl.ce_n && !ctl.le_n;

  always_ff @(posedge clk) begin
    if (rst)       store_q <= '0;
    else if (load) store_q <= din;
  end

  assign drv  = !rst && !ctl.ce_n && !ctl.oe_n;
  assign dout = drv ? store_q : '0;
endmodule

// File: rtl/xcvr_group.sv
module xcvr_group #(
  parameter int W = 8
) (
  input  logic               clk,
  input  logic               rst,
  input  xcvr_pkg::dir_ctl_t ab_ctl,
  input  xcvr_pkg::dir_ctl_t ba_ctl,
  input  logic [W-1:0]       a_side,
  input  logic [W-1:0]       b_side,
  output logic [W-1:0]       to_b,
  output logic               to_b_drv,
  output logic [W-1:0]       to_a,
  output logic               to_a_drv,
  output logic               both_on
);
  xcvr_latch_bank #(.W(W)) u_ab (
    .clk(clk), .rst(rst), .ctl(ab_ctl), .din(a_side),
    .dout(to_b), .drv(to_b_drv)
  );

  xcvr_latch_bank #(.W(W)) u_ba (
    .clk(clk), .rst(rst), .ctl(ba_ctl), .din(b_side),
    .dout(to_a), .drv(to_a_drv)
  );

  assign both_on = to_b_drv && to_a_drv;
endmodule

// File: rtl/dual_latch_xcvr.sv
module dual_latch_xcvr #(
  parameter int GROUPS = 2,
  parameter int GW     = 8,
  localparam int DW    = GROUPS * GW
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [DW-1:0]     a_in,
  input  logic [DW-1:0]     b_in,
  input  logic [GROUPS-1:0] ab_ce_n,
  input  logic [GROUPS-1:0] ab_le_n,
  input  logic [GROUPS-1:0] ab_oe_n,
  input  logic [GROUPS-1:0] ba_ce_n,
  input  logic [GROUPS-1:0] ba_le_n,
  input  logic [GROUPS-1:0] ba_oe_n,
  output logic [DW-1:0]     b_out,
  output logic [GROUPS-1:0] b_drv,
  output logic [DW-1:0]     a_out,
  output logic [GROUPS-1:0] a_drv,
  output logic [GROUPS-1:0] clash
);
  for (genvar g = 0; g < GROUPS; g++) begin : g_grp
    xcvr_pkg::dir_ctl_t ab_c, ba_c;
    assign ab_c = '{ce_n: ab_ce_n[g], le_n: ab_le_n[g], oe_n: ab_oe_n[g]};
    assign ba_c = '{ce_n: ba_ce_n[g], le_n: ba_le_n[g], oe_n: ba_oe_n[g]};

    xcvr_group #(.W(GW)) u_grp (
      .clk(clk), .rst(rst),
      .ab_ctl(ab_c), .ba_ctl(ba_c),
      .a_side(a_in[g*GW +: GW]), .b_side(b_in[g*GW +: GW]),
      .to_b(b_out[g*GW +: GW]), .to_b_drv(b_drv[g]),
      .to_a(a_out[g*GW +: GW]), .to_a_drv(a_drv[g]),
      .both_on(clash[g])
    );
  end
endmodule

// File: rtl/xcvr_chk.sv
module xcvr_chk #(
  parameter int GROUPS = 2,
  parameter int GW     = 8,
  localparam int DW    = GROUPS * GW
) (
  input logic              clk,
  input logic              rst,
  input logic [DW-1:0]     a_in,
  input logic [DW-1:0]     b_in,
  input logic [GROUPS-1:0] ab_ce_n,
  input logic [GROUPS-1:0] ab_le_n,
  input logic [GROUPS-1:0] ba_ce_n,
  input logic [GROUPS-1:0] ba_le_n,
  input logic [DW-1:0]     b_out,
  input logic [GROUPS-1:0] b_drv,
  input logic [DW-1:0]     a_out,
  input logic [GROUPS-1:0] a_drv,
  input logic [GROUPS-1:0] clash
);
  for (genvar g = 0; g < GROUPS; g++) begin : g_chk
    // R2
    ab_load_chk: assert property (@(posedge clk) disable iff (rst)
      (!$past(rst) && $past(!ab_ce_n[g] && !ab_le_n[g]) && b_drv[g])
        |-> b_out[g*GW +: GW] == $past(a_in[g*GW +: GW]));
    // R3
    ab_hold_chk: assert property (@(posedge clk) disable iff (rst)
      (!$past(rst) && $past(ab_ce_n[g] || ab_le_n[g]) && b_drv[g] && $past(b_drv[g]))
        |-> $stable(b_out[g*GW +: GW]));
    // R7
    ba_load_chk: assert property (@(posedge clk) disable iff (rst)
      (!$past(rst) && $past(!ba_ce_n[g] && !ba_le_n[g]) && a_drv[g])
        |-> a_out[g*GW +: GW] == $past(b_in[g*GW +: GW]));
    // R8
    idle_zero_chk: assert property (@(posedge clk) disable iff (rst)
      (!b_drv[g] |-> b_out[g*GW +: GW] == '0) and (!a_drv[g] |-> a_out[g*GW +: GW] == '0));
    // R9
    clash_chk: assert property (@(posedge clk) disable iff (rst)
      clash[g] == (a_drv[g] && b_drv[g]));
  end
  // R10
  reset_quiet_chk: assert property (@(posedge clk)
    rst |-> (a_drv == '0 && b_drv == '0));
endmodule

bind dual_latch_xcvr xcvr_chk #(.GROUPS(GROUPS), .GW(GW)) u_chk (
  .clk(clk), .rst(rst), .a_in(a_in), .b_in(b_in),
  .ab_ce_n(ab_ce_n), .ab_le_n(ab_le_n), .ba_ce_n(ba_ce_n), .ba_le_n(ba_le_n),
  .b_out(b_out), .b_drv(b_drv), .a_out(a_out), .a_drv(a_drv), .clash(clash)
);

// File: tb/test_dual_latch_xcvr.sv
`timescale 1ns/1ps
module test_dual_latch_xcvr;
  logic clk = 0, rst = 1;
  logic [15:0] a_in = 0, b_in = 0;
  logic [1:0] ab_ce_n = 2'b11, ab_le_n = 2'b11, ab_oe_n = 2'b11;
  logic [1:0] ba_ce_n = 2'b11, ba_le_n = 2'b11, ba_oe_n = 2'b11;
  logic [15:0] b_out, a_out;
  logic [1:0] b_drv, a_drv, clash;
  int n_chk = 0, n_bad = 0;
  logic [7:0] m_ab [2];
  logic [7:0] m_ba [2];

  always #10 clk = ~clk;

  dual_latch_xcvr i_dual_latch_xcvr (
    .clk(clk), .rst(rst), .a_in(a_in), .b_in(b_in),
    .ab_ce_n(ab_ce_n), .ab_le_n(ab_le_n), .ab_oe_n(ab_oe_n),
    .ba_ce_n(ba_ce_n), .ba_le_n(ba_le_n), .ba_oe_n(ba_oe_n),
    .b_out(b_out), .b_drv(b_drv), .a_out(a_out), .a_drv(a_drv), .clash(clash)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic logic drv_exp(input logic r, input logic ce, input logic oe);
    return !r && !ce && !oe;
  endfunction

  task automatic check_all();
    for (int g = 0; g < 2; g++) begin
      logic eb, ea;
      eb = drv_exp(rst, ab_ce_n[g], ab_oe_n[g]);
      ea = drv_exp(rst, ba_ce_n[g], ba_oe_n[g]);
      chk(rst ? "R10 b_drv" : "R5 b_drv", 32'(b_drv[g]), 32'(eb));
      chk(rst ? "R10 a_drv" : "R7 a_drv", 32'(a_drv[g]), 32'(ea));
      chk(eb ? "R5 b_out" : "R8 b_out", 32'(b_out[g*8 +: 8]), eb ? 32'(m_ab[g]) : 0);
      chk(ea ? "R7 a_out" : "R8 a_out", 32'(a_out[g*8 +: 8]), ea ? 32'(m_ba[g]) : 0);
      chk("R9 clash", 32'(clash[g]), 32'(ea && eb));
    end
  endtask

  task automatic step();
    #1 check_all();
    @(posedge clk);
    for (int g = 0; g < 2; g++) begin
      if (rst) begin
        m_ab[g] = 0; m_ba[g] = 0;
      end else begin
        if (!ab_ce_n[g] && !ab_le_n[g]) m_ab[g] = a_in[g*8 +: 8];
        if (!ba_ce_n[g] && !ba_le_n[g]) m_ba[g] = b_in[g*8 +: 8];
      end
    end
    @(negedge clk);
  endtask

  initial begin
    #(200000 * 20);
    n_chk++; n_bad++;
    $display("FAIL watchdog actual=running expected=done");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    void'($urandom(32'd4242));
    m_ab[0] = 0; m_ab[1] = 0; m_ba[0] = 0; m_ba[1] = 0;
    @(negedge clk);
    a_in = 16'hFFFF; b_in = 16'hFFFF;
    ab_ce_n = 0; ab_le_n = 0; ab_oe_n = 0;
    step(); step();
    chk("R10 b_drv in reset", 32'(b_drv), 0);
    chk("R10 a_drv in reset", 32'(a_drv), 0);
    rst = 0; ab_le_n = 2'b11; ba_ce_n = 0; ba_oe_n = 0;
    #1 chk("R10 cleared bank AB", 32'(b_out), 0);
    chk("R10 cleared bank BA", 32'(a_out), 0);
    ba_ce_n = 2'b11; ba_oe_n = 2'b11;
    // R2 transparent load in group 0
    a_in = 16'h00A5; ab_le_n = 2'b10; step();
    #1 chk("R2 load", 32'(b_out[7:0]), 32'h A5);
    // R3 hold after latch enable rises
    ab_le_n = 2'b11; a_in = 16'h003C; step();
    #1 chk("R3 hold", 32'(b_out[7:0]), 32'hA5);
    // R4 chip enable high: no drive, no load
    ab_ce_n = 2'b01; ab_le_n = 2'b10; a_in = 16'h0077; step();
    #1 chk("R4 no drive", 32'(b_drv[0]), 0);
    ab_ce_n = 0; ab_le_n = 2'b11; step();
    #1 chk("R4 no load", 32'(b_out[7:0]), 32'hA5);
    // R6 load with outputs off
    ab_oe_n = 2'b11; ab_le_n = 2'b10; a_in = 16'h0099; step();
    ab_le_n = 2'b11; ab_oe_n = 0; step();
    #1 chk("R6 load while disabled", 32'(b_out[7:0]), 32'h99);
    // R1 group 1 loads alone
    ab_le_n = 2'b01; a_in = 16'h1144; step();
    ab_le_n = 2'b11; step();
    #1 chk("R1 group1 loaded", 32'(b_out[15:8]), 32'h11);
    chk("R1 group0 untouched", 32'(b_out[7:0]), 32'h99);
    // R7 reverse direction, R9 contention
    ba_ce_n = 0; ba_le_n = 2'b10; ba_oe_n = 2'b10; b_in = 16'h00C3; step();
    #1 chk("R7 a_out", 32'(a_out[7:0]), 32'hC3);
    chk("R9 clash group0", 32'(clash[0]), 1);
    chk("R9 clash group1", 32'(clash[1]), 0);
    // random phase
    for (int i = 0; i < 3000; i++) begin
      a_in = 16'($urandom); b_in = 16'($urandom);
      ab_ce_n = 2'($urandom); ab_le_n = 2'($urandom); ab_oe_n = 2'($urandom);
      ba_ce_n = 2'($urandom); ba_le_n = 2'($urandom); ba_oe_n = 2'($urandom);
      rst = ($urandom % 97) == 0;
      step();
    end
    rst = 0;
    step();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule